// File: doc/BRIEF.md
# Packed Horizontal Add/Subtract Unit

This block is a SIMD arithmetic stage that reduces neighbouring elements inside each of two packed operands, called destination and source. Each adjacent pair of signed elements is either summed or differenced. The lower element minus the higher element is the subtraction order. Every pair yields one element of the same width, and the pair results of both operands are packed into a single result vector. A 3-bit opcode picks the operation, the element width (16 or 32 bits) and, for 16-bit elements only, whether results saturate or wrap. A separate pin picks full-width (128-bit) or half-width (64-bit) operation.

Operations enter through a valid/ready input stream and leave through a valid/ready output stream, with one register stage between them. An input is taken on a clock edge where `in_valid` and `in_ready` are both high. The result appears with `out_valid` on the next edge. A result that is not taken stays unchanged. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer stalls the producer after one item. Producers must keep inputs stable while `in_valid` is high and `in_ready` is low.

Top module: `hop_unit`

## Requirements
- R1: Opcode bit 0 selects subtract (1) or add (0). Bit 1 selects 32-bit elements (1) or 16-bit elements (0). Bit 2 selects saturation (1) or wrap (0).
- R2: Horizontal add with 16-bit elements yields the low 16 bits of the sum of each adjacent pair, so overflow wraps.
- R3: Horizontal subtract yields the element at the lower bit position minus the element at the higher bit position of each pair.
- R4: With 32-bit elements (opcodes 2 and 3), add and subtract keep the low 32 bits of the result, so overflow wraps.
- R5: Saturating 16-bit add and subtract (opcodes 4 and 5) clamp each pair result to 0x7FFF on positive overflow and to 0x8000 on negative overflow.
- R6: Destination pair results fill the lower half of the active result width in ascending pair order, and source pair results fill the upper half in the same order.
- R7: With `in_wide` low, only bits 63:0 of each operand are used, the results pack into bits 63:0, and bits 127:64 of the result are zero.
- R8: Opcodes 6 and 7 (saturating with 32-bit elements) give an all-zero result with `out_illegal` high. Legal opcodes give `out_illegal` low.
- R9: An input is accepted on an edge where `in_valid` and `in_ready` are both high. Its result is presented with `out_valid` high after that edge. `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result` and `out_illegal` hold their values.
- R11: A synchronous active-high reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation valid |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_op | input | 3 | Opcode: bit0 subtract, bit1 32-bit elements, bit2 saturate |
| in_wide | input | 1 | 1 = 128-bit operands, 0 = 64-bit operands |
| in_dst | input | 128 | Destination operand |
| in_src | input | 128 | Source operand |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 128 | Packed pair results |
| out_illegal | output | 1 | Opcode was undefined; result is zero |

## Verification
Small counting values in every word show whether the destination and source pair results land in the correct halves and in ascending order. Asymmetric pairs such as 10 and 3 expose a reversed subtraction order. Operands placed at the edges of the signed range are run through both wrapping and saturating opcodes to separate clamping from wrapping, including the 32-bit carry across a word boundary. Operands whose upper 64 bits are filled with ones show whether half-width mode ignores those bits. A long randomized stream with an irregular `out_ready` pattern covers every opcode and both widths under back-pressure.

// File: rtl/hop_pkg.sv
package hop_pkg;

  localparam int OP_W    = 3;
  localparam int OPB_SUB = 0;
  localparam int OPB_DW  = 1;
  localparam int OPB_SAT = 2;

  typedef struct packed {
    logic sub;
    logic dw;
    logic sat;
    logic illegal;
  } hop_ctl_t;

endpackage

// File: rtl/hop_decode.sv
module hop_decode
  import hop_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output hop_ctl_t        ctl
);

  always_comb begin
    ctl.sub     = op[OPB_SUB];
    ctl.dw      = op[OPB_DW];
    ctl.sat     = op[OPB_SAT] & ~op[OPB_DW];
    ctl.illegal = op[OPB_SAT] &  op[OPB_DW];
  end

endmodule

// File: rtl/hop_pair.sv
module hop_pair #(
  parameter int EW = 16
) (
  input  logic [EW-1:0] lo,
  input  logic [EW-1:0] hi,
  input  logic          sub,
  input  logic          sat,
  output logic [EW-1:0] res
);

  logic [EW:0] ext_lo;
  logic [EW:0] ext_hi;
  logic [EW:0] full;
  logic        ovf;

  always_comb begin
    ext_lo = {lo[EW-1], lo};
    ext_hi = {hi[EW-1], hi};
    full   = sub ? (ext_lo - ext_hi) : (ext_lo + ext_hi);
    ovf    = full[EW] ^ full[EW-1];
    if (sat && ovf) res = {full[EW], {(EW-1){~full[EW]}}};
    else            res = full[EW-1:0];
  end

endmodule

// File: rtl/hop_half.sv
module hop_half #(
  parameter int VEC_W = 128,
  parameter int EW    = 16
) (
  input  logic [VEC_W-1:0]   opnd,
  input  logic               sub,
  input  logic               sat,
  output logic [VEC_W/2-1:0] res
);

  localparam int NP = VEC_W / (2 * EW);

  for (genvar p = 0; p < NP; p++) begin : g_pair
    hop_pair #(.EW(EW)) u_pair (
      .lo  (opnd[(2*p)*EW +: EW]),
      .hi  (opnd[(2*p+1)*EW +: EW]),
      .sub (sub),
      .sat (sat),
      .res (res[p*EW +: EW])
    );
  end

endmodule

// File: rtl/hop_pack.sv
module hop_pack #(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W/2-1:0] w_d,
  input  logic [VEC_W/2-1:0] w_s,
  input  logic [VEC_W/2-1:0] d_d,
  input  logic [VEC_W/2-1:0] d_s,
  input  logic               dw,
  input  logic               wide,
  input  logic               illegal,
  output logic [VEC_W-1:0]   res
);

  localparam int HALF = VEC_W / 2;
  localparam int QTR  = VEC_W / 4;

  logic [HALF-1:0] sel_d;
  logic [HALF-1:0] sel_s;

  always_comb begin
    sel_d = dw ? d_d : w_d;
    sel_s = dw ? d_s : w_s;
    if (illegal)   res = '0;
    else if (wide) res = {sel_s, sel_d};
    else           res = {{HALF{1'b0}}, sel_s[QTR-1:0], sel_d[QTR-1:0]};
  end

endmodule

// File: rtl/hop_unit.sv
module hop_unit
  import hop_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic             in_wide,
  input  logic [VEC_W-1:0] in_dst,
  input  logic [VEC_W-1:0] in_src,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_result,
  output logic             out_illegal
);

  localparam int HALF = VEC_W / 2;

  hop_ctl_t        ctl;
  logic [HALF-1:0] w_d, w_s, d_d, d_s;
  logic [VEC_W-1:0] packed_res;
  logic            accept;

  hop_decode u_dec (.op(in_op), .ctl(ctl));

  hop_half #(.VEC_W(VEC_W), .EW(16)) u_w_d (
    .opnd(in_dst), .sub(ctl.sub), .sat(ctl.sat), .res(w_d));
  hop_half #(.VEC_W(VEC_W), .EW(16)) u_w_s (
    .opnd(in_src), .sub(ctl.sub), .sat(ctl.sat), .res(w_s));
  hop_half #(.VEC_W(VEC_W), .EW(32)) u_d_d (
    .opnd(in_dst), .sub(ctl.sub), .sat(1'b0), .res(d_d));
  hop_half #(.VEC_W(VEC_W), .EW(32)) u_d_s (
    .opnd(in_src), .sub(ctl.sub), .sat(1'b0), .res(d_s));

  hop_pack #(.VEC_W(VEC_W)) u_pack (
    .w_d(w_d), .w_s(w_s), .d_d(d_d), .d_s(d_s),
    .dw(ctl.dw), .wide(in_wide), .illegal(ctl.illegal),
    .res(packed_res));

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else begin
      if (accept) begin
        out_valid   <= 1'b1;
        out_result  <= packed_res;
        out_illegal <= ctl.illegal;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/hop_unit_chk.sv
module hop_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic             in_wide,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_result,
  input logic             out_illegal
);

  // R11
  rst_clears_valid_chk: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R9
  accept_gives_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R9
  empty_is_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_result) && $stable(out_illegal)));

  // R8
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_result == '0));

  // R8
  illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op[2] && in_op[1]) |=> out_illegal);

  // R7
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_wide) |=> (out_result[VEC_W-1:VEC_W/2] == '0));

endmodule

bind hop_unit hop_unit_chk #(.VEC_W(VEC_W)) u_hop_unit_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_wide(in_wide), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result), .out_illegal(out_illegal));

// File: tb/test_hop_unit.sv
module test_hop_unit;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   in_op = '0;
  logic         in_wide = 1'b0;
  logic [127:0] in_dst = '0;
  logic [127:0] in_src = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_result;
  logic         out_illegal;

  always #2.5 clk = ~clk;

  hop_unit #(.VEC_W(128)) i_hop_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_wide(in_wide), .in_dst(in_dst), .in_src(in_src),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_illegal(out_illegal));

  typedef struct {
    logic [127:0] res;
    logic         ill;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  logic hold_all = 1'b0;
  logic bp_en = 1'b0;
  int   cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic longint elem(input logic [127:0] v, input int idx, input int ew);
    if (ew == 16) return longint'($signed(v[idx*16 +: 16]));
    return longint'($signed(v[idx*32 +: 32]));
  endfunction

  // Reference from requirements R1..R8
  task automatic model(input logic [2:0] op, input logic wide,
                       input logic [127:0] d, input logic [127:0] s,
                       output logic [127:0] res, output logic ill);
    int ew, np;
    longint a, b, r;
    res = '0;
    ill = op[2] & op[1];
    if (ill) return;
    ew = op[1] ? 32 : 16;
    np = (wide ? 128 : 64) / (2 * ew);
    for (int k = 0; k < 2 * np; k++) begin
      logic [127:0] v;
      int pi;
      v  = (k < np) ? d : s;
      pi = (k < np) ? k : k - np;
      a = elem(v, 2*pi, ew);
      b = elem(v, 2*pi + 1, ew);
      r = op[0] ? (a - b) : (a + b);
      if (op[2]) begin
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
      end
      if (ew == 16) res[k*16 +: 16] = r[15:0];
      else          res[k*32 +: 32] = r[31:0];
    end
  endtask

  task automatic send(input logic [2:0] op, input logic wide,
                      input logic [127:0] d, input logic [127:0] s,
                      input logic [127:0] eres, input logic eill, input string tag);
    exp_t e;
    @(negedge clk);
    in_op = op; in_wide = wide; in_dst = d; in_src = s; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    e.res = eres; e.ill = eill; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic send_m(input logic [2:0] op, input logic wide,
                        input logic [127:0] d, input logic [127:0] s, input string tag);
    logic [127:0] r;
    logic i;
    model(op, wide, d, s, r, i);
    send(op, wide, d, s, r, i, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  logic         prev_stall = 1'b0;
  logic [127:0] prev_res = '0;
  logic         prev_ill = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = !hold_all && (!bp_en || (cyc % 3 != 0) || (cyc % 7 == 0));
      #1;
      if (rst) begin
        prev_stall = 1'b0;
      end else begin
        if (prev_stall)
          chk(out_valid && out_result == prev_res && out_illegal == prev_ill,
              "R10 hold under stall", out_result, prev_res);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R9 unexpected output", out_result, '0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(out_result == e.res, e.tag, out_result, e.res);
            chk(out_illegal == e.ill, {e.tag, " R8 flag"},
                {127'b0, out_illegal}, {127'b0, e.ill});
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_res   = out_result;
        prev_ill   = out_illegal;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R11 valid low in reset", {127'b0, out_valid}, '0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(in_ready, "R9 ready when empty", {127'b0, in_ready}, 128'd1);

    // R6 packing order, add16 full width
    send(3'd0, 1'b1,
         128'h0008_0007_0006_0005_0004_0003_0002_0001,
         128'h0050_0046_003C_0032_0028_001E_0014_000A,
         128'h0096_006E_0046_001E_000F_000B_0007_0003, 1'b0, "R6 pack order");
    // R3 subtract order
    send(3'd1, 1'b1,
         128'h0000_0000_0000_0000_0000_0000_0003_000A,
         128'h0000_0000_0000_0000_0000_0000_0005_0000,
         128'h0000_0000_0000_FFFB_0000_0000_0000_0007, 1'b0, "R3 sub order");
    // R5 saturating add, narrow, upper garbage (R7)
    send(3'd4, 1'b0,
         {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_8000_7000_7000},
         {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0002_0001},
         128'h0000_0000_0000_0000_0000_0003_8000_7FFF, 1'b0, "R5 sat add R7");
    // R2 wrapping add, same operands
    send(3'd0, 1'b0,
         {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_8000_7000_7000},
         {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0002_0001},
         128'h0000_0000_0000_0000_0000_0003_7FFF_E000, 1'b0, "R2 wrap add R7");
    // R5 saturating subtract
    send(3'd5, 1'b0, 128'h0000_0000_0000_0000_FFFF_7FFF_0001_8000, '0,
         128'h0000_0000_0000_0000_0000_0000_7FFF_8000, 1'b0, "R5 sat sub");
    // R4 32-bit wrap
    send(3'd2, 1'b1, {32'h6, 32'h5, 32'h1, 32'h7FFF_FFFF},
         {32'h0, 32'h0, 32'hFFFF_FFFF, 32'h3},
         128'h0000_0000_0000_0002_0000_000B_8000_0000, 1'b0, "R4 dword wrap");
    // R4 32-bit subtract narrow
    send_m(3'd3, 1'b0, {64'hDEAD_BEEF_0000_0001, 64'h0000_0001_8000_0000},
           {64'h1234_5678_9ABC_DEF0, 64'h0000_0002_0000_0005}, "R4 dword sub R7");
    // R8 illegal opcodes
    send(3'd6, 1'b1, {4{32'h1234_5678}}, {4{32'h9ABC_DEF0}}, '0, 1'b1, "R8 op6");
    send(3'd7, 1'b0, {4{32'h1234_5678}}, {4{32'h9ABC_DEF0}}, '0, 1'b1, "R8 op7");
    idle();

    // R1 every opcode, random data, under back-pressure (R9 R10)
    bp_en = 1'b1;
    for (int n = 0; n < 300; n++) begin
      logic [2:0] op;
      op = 3'(n % 8);
      send_m(op, 1'($urandom % 2),
             {$urandom, $urandom, $urandom, $urandom},
             {$urandom, $urandom, $urandom, $urandom}, "R1 random op");
      if (n % 11 == 0) idle();
    end
    idle();
    while (exp_q.size() != 0) @(negedge clk);
    bp_en = 1'b0;

    // R11 reset clears pending result
    hold_all = 1'b1;
    send_m(3'd0, 1'b1, 128'd5, 128'd6, "R11 discarded");
    idle();
    repeat (2) @(negedge clk);
    #1;
    chk(out_valid, "R9 result held", {127'b0, out_valid}, 128'd1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk(!out_valid, "R11 reset clears valid", {127'b0, out_valid}, '0);
    rst = 1'b0;
    exp_q.delete();
    hold_all = 1'b0;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule